// File: doc/BRIEF.md
# Page-table entry accessed/dirty flag updater

This block sits beside a page-table walker. Once the walker has found a leaf entry, it passes the block the physical address of that entry, the 32-bit entry value it used, and whether the access is a store. The block then makes sure that the entry in memory has its accessed flag set, and also its dirty flag when the access is a store. If both flags already cover the access, the block finishes at once and touches no memory.

When an update is needed, a runtime enable chooses what happens. With the enable clear, the block raises a page fault so that software can set the flags. With the enable set, the block runs an atomic compare-and-swap on the memory port: it re-reads the entry and compares it with the value the walker used. On a match it writes back the whole 32-bit word with the flags set. On a mismatch it writes nothing and asks the walker to start the walk again. The block holds a lock output for the whole read-compare-write sequence. An error response from memory, such as a protection failure on the implicit store, is reported as an access fault.

Each request ends in exactly one of four single-cycle result pulses: done, page fault, access fault or restart.

Top module: `pte_ad_updater`

## Requirements
- R1: While reset is active and right after it, all four result outputs, mem_req_o and mem_lock_o are low.
- R2: If the entry has bit 6 (accessed) set, and for a store also bit 7 (dirty) set, done_o pulses on the cycle after the request is accepted, and no memory request is made.
- R3: A load does not need bit 7. A load whose entry has bit 6 set and bit 7 clear takes the R2 path.
- R4: When an update is needed and hw_upd_en_i is low, page_fault_o pulses and no memory request is made.
- R5: When an update is needed and hw_upd_en_i is high, the block issues exactly one read (mem_we_o low) to the request address, then compares the returned word with the request entry value.
- R6: On a match, the block issues exactly one full-word write to the same address. The write data is the request entry value with bit 6 set, and with bit 7 also set for a store. A clean write response ends in done_o.
- R7: On a mismatch, no write is issued and restart_o pulses.
- R8: An error response to either the read or the write ends in access_fault_o.
- R9: mem_lock_o is high on every cycle from the read request through the last memory response or the mismatch decision, and is low on the cycle the result pulses.
- R10: Each accepted request produces exactly one result pulse, one cycle wide, on exactly one of done_o, page_fault_o, access_fault_o and restart_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request strobe, sampled only when idle |
| req_addr_i | input | AW | Physical address of the leaf entry |
| req_pte_i | input | 32 | Entry value the walker used |
| req_store_i | input | 1 | Access is a store |
| hw_upd_en_i | input | 1 | 1: update flags in hardware, 0: trap to software |
| mem_req_o | output | 1 | Memory request, one cycle per transfer |
| mem_we_o | output | 1 | Request is a write |
| mem_addr_o | output | AW | Memory address |
| mem_wdata_o | output | 32 | Write data |
| mem_lock_o | output | 1 | Keeps other masters off the entry |
| mem_rvalid_i | input | 1 | Response for the outstanding request |
| mem_rdata_i | input | 32 | Read data |
| mem_err_i | input | 1 | Response carries an error (protection failure) |
| done_o | output | 1 | Flags are set in memory |
| page_fault_o | output | 1 | Software must set the flags |
| access_fault_o | output | 1 | Memory rejected the implicit access |
| restart_o | output | 1 | Entry changed; walk again |

## Verification
The hardest case to reach is the race in which the word re-read under lock differs from the value the walker used. Only after that mismatch does the block abandon a write it has already prepared. Getting there needs the enable set, flags that actually require an update, and memory contents that diverge from the request. The bench's memory model therefore holds its own copy of the word, which is either equal to the request or has one random bit flipped. Response latency (0 to 3 cycles) and error injection on the read or write phase are randomised, so the lock window and the access-fault exits are reached from every state that waits on memory.

// File: rtl/pte_ad_pkg.sv
package pte_ad_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READ,
    ST_COMPARE,
    ST_WRITE,
    ST_DONE
  } ad_state_e;

  // result code; values index the one-hot output vector
  typedef enum logic [1:0] {
    RES_OK      = 2'd0,
    RES_PF      = 2'd1,
    RES_AF      = 2'd2,
    RES_RESTART = 2'd3
  } ad_res_e;

  localparam int unsigned NUM_RES = 4;
endpackage

// File: rtl/pte_ad_flags.sv
// Flag requirement check and merged write-back value.
module pte_ad_flags #(
  parameter int unsigned PTE_W = 32,
  parameter int unsigned A_BIT = 6,
  parameter int unsigned D_BIT = 7
) (
  input  logic [PTE_W-1:0] pte_i,
  input  logic             store_i,
  output logic             need_upd_o,
  output logic [PTE_W-1:0] new_pte_o
);
  assign need_upd_o = !pte_i[A_BIT] || (store_i && !pte_i[D_BIT]);

  for (genvar b = 0; b < PTE_W; b++) begin : g_bit
    if (b == A_BIT) begin : g_a
      assign new_pte_o[b] = 1'b1;
    end else if (b == D_BIT) begin : g_d
      assign new_pte_o[b] = pte_i[b] | store_i;
    end else begin : g_keep
      assign new_pte_o[b] = pte_i[b];
    end
  end
endmodule

// File: rtl/pte_ad_dpath.sv
// Request capture, re-read capture and compare.
module pte_ad_dpath #(
  parameter int unsigned AW    = 34,
  parameter int unsigned PTE_W = 32,
  parameter int unsigned A_BIT = 6,
  parameter int unsigned D_BIT = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cap_req_i,
  input  logic [AW-1:0]    req_addr_i,
  input  logic [PTE_W-1:0] req_pte_i,
  input  logic             req_store_i,
  input  logic             cap_rd_i,
  input  logic [PTE_W-1:0] rdata_i,
  output logic             need_upd_o,
  output logic             match_o,
  output logic [AW-1:0]    addr_o,
  output logic [PTE_W-1:0] wdata_o
);
  logic [AW-1:0]    addr_q;
  logic [PTE_W-1:0] exp_q, rd_q;
  logic             store_q;
  logic             unused_need;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q  <= '0;
      exp_q   <= '0;
      store_q <= 1'b0;
    end else if (cap_req_i) begin
      addr_q  <= req_addr_i;
      exp_q   <= req_pte_i;
      store_q <= req_store_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       rd_q <= '0;
    else if (cap_rd_i) rd_q <= rdata_i;
  end

  // decision on the incoming entry
  pte_ad_flags #(.PTE_W(PTE_W), .A_BIT(A_BIT), .D_BIT(D_BIT)) u_in_flags (
    .pte_i      (req_pte_i),
    .store_i    (req_store_i),
    .need_upd_o (need_upd_o),
    .new_pte_o  ()
  );

  // write-back value from the captured entry
  pte_ad_flags #(.PTE_W(PTE_W), .A_BIT(A_BIT), .D_BIT(D_BIT)) u_wb_flags (
    .pte_i      (exp_q),
    .store_i    (store_q),
    .need_upd_o (unused_need),
    .new_pte_o  (wdata_o)
  );

  assign match_o = (rd_q == exp_q);
  assign addr_o  = addr_q;
endmodule

// File: rtl/pte_ad_ctrl.sv
// Sequencer for the locked read-compare-write.
module pte_ad_ctrl
  import pte_ad_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    req_valid_i,
  input  logic    need_upd_i,
  input  logic    hw_en_i,
  input  logic    match_i,
  input  logic    mem_rvalid_i,
  input  logic    mem_err_i,
  output logic    cap_req_o,
  output logic    cap_rd_o,
  output logic    mem_req_o,
  output logic    mem_we_o,
  output logic    mem_lock_o,
  output logic    res_valid_o,
  output ad_res_e res_o
);
  ad_state_e state_q, state_d;
  ad_res_e   res_q, res_d;
  logic      sent_q, sent_d;

  always_comb begin
    state_d   = state_q;
    res_d     = res_q;
    cap_req_o = 1'b0;
    cap_rd_o  = 1'b0;
    mem_req_o = 1'b0;
    mem_we_o  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (req_valid_i) begin
          cap_req_o = 1'b1;
          if (!need_upd_i) begin
            res_d   = RES_OK;
            state_d = ST_DONE;
          end else if (!hw_en_i) begin
            res_d   = RES_PF;
            state_d = ST_DONE;
          end else begin
            state_d = ST_READ;
          end
        end
      end
      ST_READ: begin
        mem_req_o = !sent_q;
        if (mem_rvalid_i) begin
          if (mem_err_i) begin
            res_d   = RES_AF;
            state_d = ST_DONE;
          end else begin
            cap_rd_o = 1'b1;
            state_d  = ST_COMPARE;
          end
        end
      end
      ST_COMPARE: begin
        if (match_i) begin
          state_d = ST_WRITE;
        end else begin
          res_d   = RES_RESTART;
          state_d = ST_DONE;
        end
      end
      ST_WRITE: begin
        mem_req_o = !sent_q;
        mem_we_o  = 1'b1;
        if (mem_rvalid_i) begin
          res_d   = mem_err_i ? RES_AF : RES_OK;
          state_d = ST_DONE;
        end
      end
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  // one issue per phase; cleared whenever the phase changes
  assign sent_d = (state_d == state_q) ? (sent_q | mem_req_o) : 1'b0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      res_q   <= RES_OK;
      sent_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      res_q   <= res_d;
      sent_q  <= sent_d;
    end
  end

  assign mem_lock_o  = (state_q == ST_READ) || (state_q == ST_COMPARE) ||
                       (state_q == ST_WRITE);
  assign res_valid_o = (state_q == ST_DONE);
  assign res_o       = res_q;
endmodule

// File: rtl/pte_ad_result.sv
// Result code to one-hot pulses.
module pte_ad_result
  import pte_ad_pkg::*;
(
  input  logic               valid_i,
  input  ad_res_e            res_i,
  output logic [NUM_RES-1:0] pulse_o
);
  for (genvar i = 0; i < NUM_RES; i++) begin : g_res
    assign pulse_o[i] = valid_i && (res_i == 2'(i));
  end
endmodule

// File: rtl/pte_ad_updater.sv
module pte_ad_updater
  import pte_ad_pkg::*;
#(
  parameter int unsigned AW    = 34,
  parameter int unsigned A_BIT = 6,
  parameter int unsigned D_BIT = 7
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_valid_i,
  input  logic [AW-1:0] req_addr_i,
  input  logic [31:0]   req_pte_i,
  input  logic          req_store_i,
  input  logic          hw_upd_en_i,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [31:0]   mem_wdata_o,
  output logic          mem_lock_o,
  input  logic          mem_rvalid_i,
  input  logic [31:0]   mem_rdata_i,
  input  logic          mem_err_i,
  output logic          done_o,
  output logic          page_fault_o,
  output logic          access_fault_o,
  output logic          restart_o
);
  localparam int unsigned PTE_W = 32;

  logic               cap_req, cap_rd, need_upd, match, res_valid;
  ad_res_e            res;
  logic [NUM_RES-1:0] pulse;

  pte_ad_dpath #(.AW(AW), .PTE_W(PTE_W), .A_BIT(A_BIT), .D_BIT(D_BIT)) u_dpath (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cap_req_i   (cap_req),
    .req_addr_i  (req_addr_i),
    .req_pte_i   (req_pte_i),
    .req_store_i (req_store_i),
    .cap_rd_i    (cap_rd),
    .rdata_i     (mem_rdata_i),
    .need_upd_o  (need_upd),
    .match_o     (match),
    .addr_o      (mem_addr_o),
    .wdata_o     (mem_wdata_o)
  );

  pte_ad_ctrl u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .req_valid_i  (req_valid_i),
    .need_upd_i   (need_upd),
    .hw_en_i      (hw_upd_en_i),
    .match_i      (match),
    .mem_rvalid_i (mem_rvalid_i),
    .mem_err_i    (mem_err_i),
    .cap_req_o    (cap_req),
    .cap_rd_o     (cap_rd),
    .mem_req_o    (mem_req_o),
    .mem_we_o     (mem_we_o),
    .mem_lock_o   (mem_lock_o),
    .res_valid_o  (res_valid),
    .res_o        (res)
  );

  pte_ad_result u_result (
    .valid_i (res_valid),
    .res_i   (res),
    .pulse_o (pulse)
  );

  assign done_o         = pulse[RES_OK];
  assign page_fault_o   = pulse[RES_PF];
  assign access_fault_o = pulse[RES_AF];
  assign restart_o      = pulse[RES_RESTART];
endmodule

// File: rtl/pte_ad_updater_sva.sv
module pte_ad_updater_sva #(
  parameter int unsigned A_BIT = 6
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        mem_req_o,
  input logic        mem_we_o,
  input logic [31:0] mem_wdata_o,
  input logic        mem_lock_o,
  input logic        done_o,
  input logic        page_fault_o,
  input logic        access_fault_o,
  input logic        restart_o
);
  logic [3:0] res;
  assign res = {done_o, page_fault_o, access_fault_o, restart_o};

  p_one_result_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(res));

  p_pulse_width_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res != 4'd0) |=> (res == 4'd0));

  p_write_locked_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_we_o) |-> mem_lock_o);

  p_lock_opens_read_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_lock_o) |-> (mem_req_o && !mem_we_o));

  p_wdata_has_a_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_we_o) |-> mem_wdata_o[A_BIT]);

  p_unlocked_at_result_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res != 4'd0) |-> !mem_lock_o);

  p_restart_after_lock_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_o |-> $past(mem_lock_o));

  p_pf_no_lock_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    page_fault_o |-> !$past(mem_lock_o));
endmodule

bind pte_ad_updater pte_ad_updater_sva #(.A_BIT(A_BIT)) u_sva (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .mem_req_o      (mem_req_o),
  .mem_we_o       (mem_we_o),
  .mem_wdata_o    (mem_wdata_o),
  .mem_lock_o     (mem_lock_o),
  .done_o         (done_o),
  .page_fault_o   (page_fault_o),
  .access_fault_o (access_fault_o),
  .restart_o      (restart_o)
);

// File: tb/pte_ad_updater_bench.sv
`timescale 1ns/1ps
module pte_ad_updater_bench;
  localparam int unsigned AW = 34;
  localparam int K_OK = 0, K_PF = 1, K_AF = 2, K_RS = 3;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          req_valid_i = 1'b0;
  logic [AW-1:0] req_addr_i = '0;
  logic [31:0]   req_pte_i = '0;
  logic          req_store_i = 1'b0;
  logic          hw_upd_en_i = 1'b0;
  logic          mem_req_o, mem_we_o, mem_lock_o;
  logic [AW-1:0] mem_addr_o;
  logic [31:0]   mem_wdata_o;
  logic          mem_rvalid_i = 1'b0;
  logic [31:0]   mem_rdata_i = '0;
  logic          mem_err_i = 1'b0;
  logic          done_o, page_fault_o, access_fault_o, restart_o;

  int n_chk = 0;
  int n_fail = 0;
  logic [31:0] mem_word;

  always #5 clk_i = ~clk_i;

  pte_ad_updater #(.AW(AW)) u_pte_ad_updater (.*);

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  function automatic bit need_upd(input logic [31:0] p, input bit st);
    return !p[6] || (st && !p[7]);
  endfunction

  task automatic run_req(input logic [AW-1:0] addr, input logic [31:0] pte,
                         input bit st, input bit en, input logic [31:0] memval,
                         input bit rd_err, input bit wr_err, input int lat);
    int  exp_kind, exp_rd, exp_wr, kind, n_pulse, n_rd, n_wr, first_c, cnt, tail;
    bit  pending, in_seq, lock_gap, lock_at_res, bad_addr, pend_we;
    logic [31:0] exp_wdata, got_wdata, exp_mem;
    exp_rd = 0; exp_wr = 0; exp_mem = memval;
    exp_wdata = pte | 32'h40 | (st ? 32'h80 : 32'h0);
    if (!need_upd(pte, st))  exp_kind = K_OK;
    else if (!en)            exp_kind = K_PF;
    else begin
      exp_rd = 1;
      if (rd_err)                exp_kind = K_AF;
      else if (memval != pte)    exp_kind = K_RS;
      else begin
        exp_wr = 1;
        exp_kind = wr_err ? K_AF : K_OK;
        if (!wr_err) exp_mem = exp_wdata;
      end
    end
    mem_word = memval;
    @(negedge clk_i);
    req_valid_i = 1'b1; req_addr_i = addr; req_pte_i = pte;
    req_store_i = st; hw_upd_en_i = en;
    kind = -1; n_pulse = 0; n_rd = 0; n_wr = 0; first_c = -1; cnt = 0; tail = 0;
    pending = 0; in_seq = 0; lock_gap = 0; lock_at_res = 0; bad_addr = 0; pend_we = 0;
    got_wdata = '0;
    for (int c = 1; c < 60; c++) begin
      @(negedge clk_i);
      req_valid_i = 1'b0;
      if (mem_rvalid_i) begin mem_rvalid_i = 1'b0; mem_err_i = 1'b0; end
      if (done_o || page_fault_o || access_fault_o || restart_o) begin
        n_pulse++;
        if (first_c < 0) first_c = c;
        if (mem_lock_o) lock_at_res = 1;
        in_seq = 0;
        kind = done_o ? K_OK : page_fault_o ? K_PF : access_fault_o ? K_AF : K_RS;
      end else if (in_seq && !mem_lock_o) lock_gap = 1;
      if (mem_req_o) begin
        if (mem_addr_o != addr) bad_addr = 1;
        if (!mem_lock_o) lock_gap = 1;
        if (mem_we_o) begin n_wr++; got_wdata = mem_wdata_o; end
        else begin n_rd++; in_seq = 1; end
        pending = 1; pend_we = mem_we_o; cnt = lat;
      end
      if (pending) begin
        if (cnt == 0) begin
          mem_rvalid_i = 1'b1;
          mem_rdata_i  = mem_word;
          mem_err_i    = pend_we ? wr_err : rd_err;
          if (pend_we && !wr_err) mem_word = got_wdata;
          pending = 0;
        end else cnt--;
      end
      if (first_c >= 0) begin
        tail++;
        if (tail > 3) break;
      end
    end
    check(kind == exp_kind, "R10", "result kind", 64'(kind), 64'(exp_kind));
    check(n_pulse == 1, "R10", "pulse count", 64'(n_pulse), 64'd1);
    check(n_rd == exp_rd, (exp_rd == 0) ? "R4" : "R5", "reads", 64'(n_rd), 64'(exp_rd));
    check(n_wr == exp_wr, (exp_kind == K_RS) ? "R7" : "R6", "writes", 64'(n_wr), 64'(exp_wr));
    if (exp_wr == 1)
      check(got_wdata == exp_wdata, "R6", "write data", 64'(got_wdata), 64'(exp_wdata));
    check(mem_word == exp_mem, "R6", "memory word", 64'(mem_word), 64'(exp_mem));
    check(!bad_addr, "R5", "address", 64'(bad_addr), 64'd0);
    check(!lock_gap && !lock_at_res, "R9", "lock window",
          64'({lock_gap, lock_at_res}), 64'd0);
    if (exp_rd == 0)
      check(first_c == 1, need_upd(pte, st) ? "R4" : "R2", "latency",
            64'(first_c), 64'd1);
    if (exp_rd == 1 && rd_err)
      check(kind == K_AF, "R8", "read error", 64'(kind), 64'(K_AF));
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    check(1'b0, "R10", "watchdog expired", 64'd0, 64'd1);
    finish_run();
  end

  initial begin
    logic [AW-1:0] a;
    logic [31:0]   p, m;
    bit            st, en, re, we;
    int            lat, r;
    void'($urandom(32'd20240611));
    repeat (2) @(negedge clk_i);
    check(!done_o && !page_fault_o && !access_fault_o && !restart_o &&
          !mem_req_o && !mem_lock_o, "R1", "in reset", 64'(done_o), 64'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check(!done_o && !page_fault_o && !access_fault_o && !restart_o &&
          !mem_req_o && !mem_lock_o, "R1", "after reset", 64'(mem_lock_o), 64'd0);

    // directed corners
    run_req(34'h0_1000_0040, 32'h0400_0CC3, 1'b1, 1'b1, 32'h0, 0, 0, 1); // R2 store, A+D set
    run_req(34'h0_1000_0044, 32'h0400_0C43, 1'b0, 1'b1, 32'h0, 0, 0, 1); // R3 load, D clear
    run_req(34'h0_1000_0048, 32'h0400_0C43, 1'b1, 1'b0, 32'h0400_0C43, 0, 0, 1); // R4
    run_req(34'h0_1000_004C, 32'h0400_0C17, 1'b1, 1'b1, 32'h0400_0C17, 0, 0, 0); // R6 store
    run_req(34'h0_1000_0050, 32'h0400_0C17, 1'b0, 1'b1, 32'h0400_0C17, 0, 0, 2); // R6 load, no D
    run_req(34'h0_1000_0054, 32'h0400_0C17, 1'b0, 1'b1, 32'h0400_0D17, 0, 0, 1); // R7 mismatch
    run_req(34'h0_1000_0058, 32'h0400_0C17, 1'b1, 1'b1, 32'h0400_0C17, 1, 0, 3); // R8 read err
    run_req(34'h0_1000_005C, 32'h0400_0C17, 1'b1, 1'b1, 32'h0400_0C17, 0, 1, 2); // R8 write err

    for (int i = 0; i < 400; i++) begin
      a   = {$urandom, $urandom} & {{(AW-2){1'b1}}, 2'b00};
      p   = $urandom;
      st  = 1'($urandom);
      en  = ($urandom % 4) != 0;
      r   = $urandom % 8;
      m   = (r < 3) ? (p ^ (32'd1 << ($urandom % 32))) : p;
      re  = ($urandom % 10) == 0;
      we  = ($urandom % 10) == 0;
      lat = $urandom % 4;
      run_req(a, p, st, en, m, re, we, lat);
    end
    finish_run();
  end
endmodule